// File: doc/BRIEF.md
# Two-Phase Count Direction Decoder

This block sits in front of a 16-bit up/down counter and turns two asynchronous external phase signals, called phase A (primary) and phase B (secondary), into a single-cycle count-enable strobe with a direction bit. The external phases are the only count source: no internal clock or prescaler can feed the counter through this block. Both phases pass through a two-flop synchronizer, then an edge detector. A combinational decoder applies the selected direction scheme, and an output register issues at most one count event per system clock.

A 3-bit mode input selects the scheme:

- **Level direction**: phase A edges count, and the level of phase B sets the direction.
- **Dual pulse**: phase A edges count up and phase B edges count down.
- **Sampled direction**: the level of phase B is taken at each phase A edge.
- **Quadrature**: all four edges are counted and the direction is decoded.

Any mode code with the top bit clear disables counting. In the three non-quadrature schemes a polarity input picks rising or falling edges as the valid ones. In quadrature mode, a step that moves both synchronized phases in one cycle is refused and latched in a sticky error flag.

Top module: `phase_dir_decoder`

## Requirements
- R1: While reset is low and directly after it, cnt_en_o, cnt_up_o and quad_err_o are 0.
- R2: With mode_i[2] = 0 (codes 000 to 011), no edge on either phase produces a count strobe.
- R3: Mode 100 (level direction): a valid edge of phase A gives one strobe, with cnt_up_o = 1 when the synchronized phase B is low and 0 when it is high. Edges of phase B alone give no strobe.
- R4: Mode 101 (dual pulse): a valid edge of phase A alone gives a strobe with cnt_up_o = 1. A valid edge of phase B alone gives a strobe with cnt_up_o = 0. Valid edges on both in the same cycle cancel, and no strobe is issued.
- R5: Mode 110 (sampled direction): a valid edge of phase A gives one strobe, with its direction taken from phase B at that edge (low means up, cnt_up_o = 1; high means down, cnt_up_o = 0). Phase B edges give no strobe.
- R6: Mode 111 (quadrature): every edge of either phase gives one strobe. The state {A,B} stepping 00→10→11→01→00 (A leading B by 90 degrees) counts up, and the reverse order counts down. Polarity is ignored.
- R7: In mode 111, a step that changes both synchronized phases in the same cycle gives no strobe and sets quad_err_o. quad_err_o stays 1 until reset.
- R8: edge_pol_i = 0 makes rising edges valid and edge_pol_i = 1 makes falling edges valid, in modes 100, 101 and 110. An edge of the other polarity gives no strobe.
- R9: A phase change driven before clock edge E1 raises cnt_en_o after clock edge E3, for exactly one cycle. There is at most one count event per clock.
- R10: cnt_up_o is 0 whenever cnt_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_a_i | input | 1 | Primary external phase, asynchronous |
| phase_b_i | input | 1 | Secondary external phase, asynchronous |
| mode_i | input | 3 | Direction scheme: 100 level, 101 dual pulse, 110 sampled, 111 quadrature, 0xx off |
| edge_pol_i | input | 1 | Valid edge for non-quadrature modes: 0 rising, 1 falling |
| cnt_en_o | output | 1 | Single-cycle count strobe |
| cnt_up_o | output | 1 | Direction qualifying cnt_en_o: 1 up, 0 down |
| quad_err_o | output | 1 | Sticky flag for an illegal quadrature step |

## Verification
A phase change takes three register stages to reach the strobe: two synchronizer flops and then the output register. The edge-detect reference register is compared against the second synchronizer flop, so it adds no stage of its own. The strobe, its direction and any new error flag therefore appear after the third rising clock edge that follows the change. The bench drives phases on a falling edge, waits three rising edges and samples on the next falling edge. It samples once more a cycle later to confirm that the pulse has ended. One directed test samples after the first and second edges as well, to show that the strobe does not come early.

// File: rtl/phase_dir_pkg.sv
package phase_dir_pkg;

    localparam int unsigned PHASE_W = 2;
    localparam int unsigned IDX_A   = 1;
    localparam int unsigned IDX_B   = 0;

    typedef enum logic [2:0] {
        MODE_OFF0   = 3'b000,
        MODE_OFF1   = 3'b001,
        MODE_OFF2   = 3'b010,
        MODE_OFF3   = 3'b011,
        MODE_LEVEL  = 3'b100,
        MODE_DUAL   = 3'b101,
        MODE_SAMPLE = 3'b110,
        MODE_QUAD   = 3'b111
    } dir_mode_e;

    typedef struct packed {
        logic en;
        logic up;
        logic err;
    } strobe_t;

endpackage

// File: rtl/phase_sync.sv
module phase_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb stage_d[0] = async_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_comb stage_d[s] = stage_q[s-1];
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_flop
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/phase_edge.sv
module phase_edge #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] sync_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sync_i;
        cur_o  = sync_i;
        prev_o = prev_q;
        rise_o = sync_i & ~prev_q;
        fall_o = ~sync_i & prev_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

endmodule

// File: rtl/phase_dir_decode.sv
module phase_dir_decode
    import phase_dir_pkg::*;
(
    input  logic [2:0]         mode_i,
    input  logic               edge_pol_i,
    input  logic [PHASE_W-1:0] cur_i,
    input  logic [PHASE_W-1:0] prev_i,
    input  logic [PHASE_W-1:0] rise_i,
    input  logic [PHASE_W-1:0] fall_i,
    output logic               en_o,
    output logic               up_o,
    output logic               illegal_o
);

    logic [PHASE_W-1:0] valid;
    logic [PHASE_W-1:0] moved;
    logic               en_raw, up_raw;

    always_comb begin
        valid     = edge_pol_i ? fall_i : rise_i;
        moved     = cur_i ^ prev_i;
        en_raw    = 1'b0;
        up_raw    = 1'b0;
        illegal_o = 1'b0;
        unique case (dir_mode_e'(mode_i))
            MODE_LEVEL, MODE_SAMPLE: begin
                en_raw = valid[IDX_A];
                up_raw = ~cur_i[IDX_B];
            end
            MODE_DUAL: begin
                en_raw = valid[IDX_A] ^ valid[IDX_B];
                up_raw = valid[IDX_A];
            end
            MODE_QUAD: begin
                if (&moved) begin
                    illegal_o = 1'b1;
                end else if (|moved) begin
                    en_raw = 1'b1;
                    up_raw = cur_i[IDX_A] ^ prev_i[IDX_B];
                end
            end
            default: begin
                en_raw = 1'b0;
            end
        endcase
        en_o = en_raw;
        up_o = en_raw & up_raw;
    end

endmodule

// File: rtl/phase_dir_decoder.sv
module phase_dir_decoder
    import phase_dir_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       phase_a_i,
    input  logic       phase_b_i,
    input  logic [2:0] mode_i,
    input  logic       edge_pol_i,
    output logic       cnt_en_o,
    output logic       cnt_up_o,
    output logic       quad_err_o
);

    logic [PHASE_W-1:0] raw_ab, sync_ab, cur_ab, prev_ab, rise_ab, fall_ab;
    logic               dec_en, dec_up, dec_illegal;
    strobe_t            out_d, out_q;

    assign raw_ab = {phase_a_i, phase_b_i};

    phase_sync #(.WIDTH(PHASE_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_ab),
        .sync_o  (sync_ab)
    );

    phase_edge #(.WIDTH(PHASE_W)) i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (sync_ab),
        .cur_o  (cur_ab),
        .prev_o (prev_ab),
        .rise_o (rise_ab),
        .fall_o (fall_ab)
    );

    phase_dir_decode i_decode (
        .mode_i     (mode_i),
        .edge_pol_i (edge_pol_i),
        .cur_i      (cur_ab),
        .prev_i     (prev_ab),
        .rise_i     (rise_ab),
        .fall_i     (fall_ab),
        .en_o       (dec_en),
        .up_o       (dec_up),
        .illegal_o  (dec_illegal)
    );

    always_comb begin
        out_d     = out_q;
        out_d.en  = dec_en;
        out_d.up  = dec_up;
        out_d.err = out_q.err | dec_illegal;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign cnt_en_o   = out_q.en;
    assign cnt_up_o   = out_q.up;
    assign quad_err_o = out_q.err;

    assert_off_modes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_i[2] |=> !cnt_en_o);

    assert_dual_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 3'b101 && !edge_pol_i && rise_ab[IDX_A] && rise_ab[IDX_B]) |=> !cnt_en_o);

    assert_quad_illegal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 3'b111 && cur_ab[IDX_A] != prev_ab[IDX_A] && cur_ab[IDX_B] != prev_ab[IDX_B])
        |=> (!cnt_en_o && quad_err_o));

    assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        quad_err_o |=> quad_err_o);

    assert_pol_falling_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 3'b100 && edge_pol_i && rise_ab[IDX_A]) |=> !cnt_en_o);

    assert_edge_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_en_o |-> $past(cur_ab != prev_ab));

    assert_dir_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_en_o |-> !cnt_up_o);

endmodule

// File: tb/test_phase_dir_decoder.sv
`timescale 1ns/100ps
module test_phase_dir_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pa = 1'b0, pb = 1'b0, pol = 1'b0;
    logic [2:0] mode = 3'b000;
    logic       en, up, err;
    int         checks = 0, fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    phase_dir_decoder i_phase_dir_decoder (
        .clk_i(clk), .rst_ni(rst_n), .phase_a_i(pa), .phase_b_i(pb),
        .mode_i(mode), .edge_pol_i(pol),
        .cnt_en_o(en), .cnt_up_o(up), .quad_err_o(err)
    );

    // fields: [7:5] mode, [4] polarity, [3] A, [2] B, [1] expected en, [0] expected up
    localparam int NV = 26;
    localparam logic [7:0] VEC [NV] = '{
        8'b100_0_10_11, 8'b100_0_11_00, 8'b100_0_01_00, 8'b100_0_11_10,  // R3, R8 (falling ignored)
        8'b000_0_01_00, 8'b000_0_11_00, 8'b011_0_00_00,                  // R2
        8'b101_0_10_11, 8'b101_0_11_10, 8'b101_0_00_00, 8'b101_0_11_00,  // R4 incl. cancel
        8'b101_1_01_11, 8'b101_1_00_10,                                  // R4 with R8 falling
        8'b110_0_01_00, 8'b110_0_11_10, 8'b110_0_00_00, 8'b110_0_10_11,  // R5
        8'b110_1_00_11,                                                  // R5 with R8 falling
        8'b111_0_10_11, 8'b111_0_11_11, 8'b111_0_01_11, 8'b111_0_00_11,  // R6 up
        8'b111_0_01_10, 8'b111_0_11_10, 8'b111_0_10_10, 8'b111_0_00_10   // R6 down
    };

    function automatic string tag_of(logic [2:0] m);
        if (!m[2])           return "R2";
        else if (m == 3'b100) return "R3";
        else if (m == 3'b101) return "R4";
        else if (m == 3'b110) return "R5";
        return "R6";
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic apply(logic a, logic b, logic e_en, logic e_up, logic e_err, string req);
        @(negedge clk);
        pa = a; pb = b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req, "cnt_en", en, e_en);
        check(req, "cnt_up", up, e_up);
        check(req, "quad_err", err, e_err);
        @(negedge clk);
        check("R9", "pulse ended", en, 1'b0);
        check("R10", "dir idle", up, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "en in reset", en, 1'b0);
        check("R1", "up in reset", up, 1'b0);
        check("R1", "err in reset", err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "en after reset", en, 1'b0);

        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][7:5];
            pol  = VEC[i][4];
            apply(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b0, tag_of(VEC[i][7:5]));
        end

        // R9 latency: state is A=0,B=0
        mode = 3'b101; pol = 1'b0;
        @(negedge clk);
        pa = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9", "no strobe after E1", en, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R9", "no strobe after E2", en, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R9", "strobe after E3", en, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R9", "strobe gone after E4", en, 1'b0);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");

        // R7 illegal quadrature step and stickiness
        mode = 3'b111;
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
        mode = 3'b000;
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "err cleared by reset", err, 1'b0);
        check("R1", "en cleared by reset", en, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule